// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples an A bus to a B bus through a number of independent byte-wide lanes. It is two lanes by default, which gives a 16-bit path. Every lane has its own controls, so the lanes can work as separate 8-bit transceivers. They can also be tied together and used as one wide transceiver.

Each lane holds two storage registers:
- One register takes a snapshot of the A bus when the lane's A-to-B capture strobe rises.
- The other register takes a snapshot of the B bus when the lane's B-to-A capture strobe rises.

For each direction, a select input picks what goes to the far side. Low passes the live bus value across. High sends the stored snapshot.

The two directions have enables of opposite sense:
- The A-to-B enable is active high.
- The B-to-A enable is active low.

Each tri-state pin is modelled as three parts: an input vector, an output vector, and a lane-wide output enable. The surrounding logic resolves the bus.

All lane outputs and enables leave the block through a register clocked by the system clock `clk`. A source change therefore reaches the pins exactly one clock later, and never as an intermediate value. When both directions are enabled in live mode, the registered loop A→B→A keeps both buses at their last level once outside drivers let go. A synchronous reset stands in for power-up. It clears both snapshots and turns both enables off.

Top module: `reg_xcvr`

## Requirements
- R1: Each lane (bits [8k+7:8k]) responds only to its own bit k of every control input; controls of one lane never change another lane's outputs or snapshots.
- R2: A 0→1 change of `cap_ab[k]` seen between two clock edges loads lane k of `a_in` into the A snapshot at the second edge, and likewise `cap_ba[k]` loads `b_in` into the B snapshot; a strobe held high loads nothing further.
- R3: Snapshot loading takes place whatever the levels of `sel_ab`, `sel_ba`, `en_ab` and `en_ba_n`, including while both directions are disabled.
- R4: With `sel_ab[k]`=0, lane k of `b_out` equals lane k of `a_in` one clock earlier; with `sel_ba[k]`=0, lane k of `a_out` equals lane k of `b_in` one clock earlier.
- R5: With `sel_ab[k]`=1, lane k of `b_out` shows the A snapshot; with `sel_ba[k]`=1, lane k of `a_out` shows the B snapshot; both appear one clock after the select.
- R6: `b_oe[k]` follows `en_ab[k]` (1 = drive B) and `a_oe[k]` follows the inverse of `en_ba_n[k]` (0 = drive A), each one clock later.
- R7: After a select changes, the lane output moves straight from the old source's value to the new source's value at one clock edge and then stays on the new source.
- R8: With both directions enabled and both selects 0, once all external drivers release, both buses keep the last value indefinitely.
- R9: While `rst` is 1, `a_oe` and `b_oe` are 0 from the next edge on; after reset both snapshots read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; capture strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset standing in for power-up |
| en_ab | input | LANES | A-to-B drive enable per lane, active high |
| en_ba_n | input | LANES | B-to-A drive enable per lane, active low |
| cap_ab | input | LANES | Strobe: rising level loads A bus into A snapshot |
| cap_ba | input | LANES | Strobe: rising level loads B bus into B snapshot |
| sel_ab | input | LANES | 0 = live A data to B, 1 = A snapshot to B |
| sel_ba | input | LANES | 0 = live B data to A, 1 = B snapshot to A |
| a_in | input | LANES*LANE_W | Resolved A bus level |
| a_out | output | LANES*LANE_W | Value driven onto A bus |
| a_oe | output | LANES | Drive A bus, per lane |
| b_in | input | LANES*LANE_W | Resolved B bus level |
| b_out | output | LANES*LANE_W | Value driven onto B bus |
| b_oe | output | LANES | Drive B bus, per lane |

## Verification
The snapshots are invisible until a select chooses them. A wrongly loaded or wrongly held snapshot therefore shows up only on the first clock edge after the matching select goes high. The bench forces that exposure right after each capture case, including captures made while both directions are disabled. Faults in the live path, the enables or the lane separation show on the very next clock edge. In the self-hold case a single wrong bit circulates through the loop and stays on both buses, so it can be caught several cycles later.

// File: rtl/reg_xcvr.sv
module reg_xcvr #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0]          en_ab,
  input  logic [LANES-1:0]          en_ba_n,
  input  logic [LANES-1:0]          cap_ab,
  input  logic [LANES-1:0]          cap_ba,
  input  logic [LANES-1:0]          sel_ab,
  input  logic [LANES-1:0]          sel_ba,
  input  logic [LANES*LANE_W-1:0]   a_in,
  output logic [LANES*LANE_W-1:0]   a_out,
  output logic [LANES-1:0]          a_oe,
  input  logic [LANES*LANE_W-1:0]   b_in,
  output logic [LANES*LANE_W-1:0]   b_out,
  output logic [LANES-1:0]          b_oe
);

  localparam int W = LANES * LANE_W;

  logic [W-1:0] held_a;
  logic [W-1:0] held_b;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LO = k * LANE_W;

    logic [LANE_W-1:0] snap_a, snap_b, drv_a, drv_b;
    logic              strb_ab_q, strb_ba_q, oe_a_q, oe_b_q;
    logic              load_a, load_b;

    assign load_a = cap_ab[k] & ~strb_ab_q;
    assign load_b = cap_ba[k] & ~strb_ba_q;

    always_ff @(posedge clk) begin
      strb_ab_q <= cap_ab[k];
      strb_ba_q <= cap_ba[k];
      if (rst) begin
        snap_a <= '0;
        snap_b <= '0;
        drv_a  <= '0;
        drv_b  <= '0;
        oe_a_q <= 1'b0;
        oe_b_q <= 1'b0;
      end else begin
        if (load_a) snap_a <= a_in[LO +: LANE_W];
        if (load_b) snap_b <= b_in[LO +: LANE_W];
        drv_b  <= sel_ab[k] ? snap_a : a_in[LO +: LANE_W];
        drv_a  <= sel_ba[k] ? snap_b : b_in[LO +: LANE_W];
        oe_b_q <= en_ab[k];
        oe_a_q <= ~en_ba_n[k];
      end
    end

    assign b_out[LO +: LANE_W]  = drv_b;
    assign a_out[LO +: LANE_W]  = drv_a;
    assign b_oe[k]              = oe_b_q;
    assign a_oe[k]              = oe_a_q;
    assign held_a[LO +: LANE_W] = snap_a;
    assign held_b[LO +: LANE_W] = snap_b;
  end

endmodule

// File: rtl/reg_xcvr_chk.sv
module reg_xcvr_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES-1:0]        en_ab,
  input logic [LANES-1:0]        en_ba_n,
  input logic [LANES-1:0]        cap_ab,
  input logic [LANES-1:0]        cap_ba,
  input logic [LANES-1:0]        sel_ab,
  input logic [LANES-1:0]        sel_ba,
  input logic [LANES*LANE_W-1:0] a_in,
  input logic [LANES*LANE_W-1:0] a_out,
  input logic [LANES-1:0]        a_oe,
  input logic [LANES*LANE_W-1:0] b_in,
  input logic [LANES*LANE_W-1:0] b_out,
  input logic [LANES-1:0]        b_oe,
  input logic [LANES*LANE_W-1:0] held_a,
  input logic [LANES*LANE_W-1:0] held_b
);

  assert_reset_off_R9: assert property (@(posedge clk)
    rst |=> (a_oe == '0 && b_oe == '0 && held_a == '0 && held_b == '0));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    localparam int LO = k * LANE_W;

    assert_oe_ab_R6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> b_oe[k] == $past(en_ab[k]));
    assert_oe_ba_R6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> a_oe[k] == !$past(en_ba_n[k]));

    assert_live_ab_R4: assert property (@(posedge clk) disable iff (rst)
      !sel_ab[k] |=> b_out[LO +: LANE_W] == $past(a_in[LO +: LANE_W]));
    assert_live_ba_R4: assert property (@(posedge clk) disable iff (rst)
      !sel_ba[k] |=> a_out[LO +: LANE_W] == $past(b_in[LO +: LANE_W]));

    assert_stored_ab_R5: assert property (@(posedge clk) disable iff (rst)
      sel_ab[k] |=> b_out[LO +: LANE_W] == $past(held_a[LO +: LANE_W]));
    assert_stored_ba_R5: assert property (@(posedge clk) disable iff (rst)
      sel_ba[k] |=> a_out[LO +: LANE_W] == $past(held_b[LO +: LANE_W]));

    assert_load_a_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(cap_ab[k]) |=> held_a[LO +: LANE_W] == $past(a_in[LO +: LANE_W]));
    assert_load_b_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(cap_ba[k]) |=> held_b[LO +: LANE_W] == $past(b_in[LO +: LANE_W]));

    assert_keep_a_R2: assert property (@(posedge clk) disable iff (rst)
      !$rose(cap_ab[k]) |=> $stable(held_a[LO +: LANE_W]));
    assert_keep_b_R2: assert property (@(posedge clk) disable iff (rst)
      !$rose(cap_ba[k]) |=> $stable(held_b[LO +: LANE_W]));
  end

endmodule

bind reg_xcvr reg_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .en_ab(en_ab), .en_ba_n(en_ba_n),
  .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
  .held_a(held_a), .held_b(held_b)
);

// File: tb/reg_xcvr_tb.sv
`timescale 1ns/1ps
module reg_xcvr_tb;
  localparam int LANES = 2;
  localparam int LW    = 8;
  localparam int W     = LANES * LW;

  localparam logic [W-1:0] PAT [8] = '{16'h0000, 16'hFFFF, 16'hA55A, 16'h5AA5,
                                       16'h0180, 16'h7E01, 16'hC33C, 16'h1234};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES-1:0] en_ab = '0, en_ba_n = '1, cap_ab = '0, cap_ba = '0;
  logic [LANES-1:0] sel_ab = '0, sel_ba = '0, ext_a_on = '0, ext_b_on = '0;
  logic [W-1:0] ext_a = '0, ext_b = '0, keep_a = '0, keep_b = '0;
  logic [W-1:0] a_bus, b_bus, a_out, b_out;
  logic [LANES-1:0] a_oe, b_oe;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  reg_xcvr #(.LANES(LANES), .LANE_W(LW)) u_dut (
    .clk(clk), .rst(rst), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_bus), .b_out(b_out), .b_oe(b_oe));

  always_comb begin
    for (int i = 0; i < W; i++) begin
      a_bus[i] = ext_a_on[i/LW] ? ext_a[i] : (a_oe[i/LW] ? a_out[i] : keep_a[i]);
      b_bus[i] = ext_b_on[i/LW] ? ext_b[i] : (b_oe[i/LW] ? b_out[i] : keep_b[i]);
    end
  end

  always @(posedge clk) begin
    keep_a <= a_bus;
    keep_b <= b_bus;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    en_ab = '1;
    tick(2);
    check("R9 b_oe off in reset", W'(b_oe), '0);
    check("R9 a_oe off in reset", W'(a_oe), '0);
    sel_ab = '1; sel_ba = '1; en_ab = '0;
    rst = 1'b0;
    tick(1);
    check("R9 A snapshot cleared", b_out, '0);
    check("R9 B snapshot cleared", a_out, '0);

    sel_ab = '0; sel_ba = '0;
    foreach (PAT[i]) begin
      en_ab = '1; en_ba_n = '1; ext_b_on = '0; ext_a_on = '1; ext_a = PAT[i];
      tick(1);
      check("R4 live A->B", b_out, PAT[i]);
      check("R6 b_oe active high", W'(b_oe), W'(2'b11));
      check("R6 a_oe off", W'(a_oe), '0);
      en_ab = '0; en_ba_n = '0; ext_a_on = '0; ext_b_on = '1; ext_b = ~PAT[i];
      tick(1);
      check("R4 live B->A", a_out, ~PAT[i]);
      check("R6 a_oe active low", W'(a_oe), W'(2'b11));
      check("R6 b_oe off", W'(b_oe), '0);
    end

    en_ab = '0; en_ba_n = '1; ext_b_on = '0; ext_a_on = '1; ext_a = 16'h3C96;
    tick(1);
    cap_ab = '1;
    tick(1);
    ext_a = 16'h0F0F;
    tick(2);
    cap_ab = '0; sel_ab = '1; en_ab = '1;
    tick(1);
    check("R3 capture while disabled, R2 level no reload", b_out, 16'h3C96);

    ext_b_on = '1; ext_b = 16'h8E71; en_ab = '0;
    tick(1);
    cap_ba = '1;
    tick(1);
    cap_ba = '0; ext_b = 16'h1111;
    tick(1);
    ext_a_on = '0; sel_ba = '1; en_ba_n = '0;
    tick(1);
    check("R5 B snapshot to A", a_out, 16'h8E71);
    check("R2 A snapshot kept", b_out, 16'h3C96);

    en_ba_n = '1; ext_a_on = '1; ext_a = 16'h0F0F; sel_ab = '0; en_ab = '1;
    tick(1);
    check("R7 live before switch", b_out, 16'h0F0F);
    sel_ab = '1;
    for (int c = 0; c < 3; c++) begin
      tick(1);
      check("R7 stored right after switch", b_out, 16'h3C96);
    end

    ext_a = 16'h4B2D; sel_ab = 2'b01;
    tick(1);
    check("R1 lane0 stored lane1 live", b_out, 16'h4B96);
    ext_a = 16'hD24B; cap_ab = 2'b10;
    tick(1);
    cap_ab = '0; sel_ab = '1; ext_a = 16'h0000;
    tick(1);
    check("R1 only lane1 captured", b_out, 16'hD296);

    sel_ab = '0; sel_ba = '0; en_ab = '1; en_ba_n = '0;
    ext_b_on = '0; ext_a_on = '1; ext_a = 16'h6B19;
    tick(3);
    ext_a_on = '0;
    tick(6);
    check("R8 A bus self-held", a_bus, 16'h6B19);
    check("R8 B bus self-held", b_bus, 16'h6B19);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule